// File: doc/BRIEF.md
# Sample-and-convert timing sequencer

This block is the digital sequencer for a 10-bit successive-approximation converter. A start request opens a sampling window, during which `samp_en` is high. Conversion then runs at once, with `conv_en` high. During conversion the block offers a trial code to an external comparator and builds the result one bit per step, starting at the most significant bit. When the last bit is decided, the result is held in an output register and `data_rdy` goes high.

There are two start modes. In strobe mode (`mode_hw` = 0), a rising edge on `rd_strb`, `wr_strb` or `go_pin` starts a sampling window of fixed length. In pin mode (`mode_hw` = 1), the window opens when `go_pin` falls and closes when `go_pin` rises, so the pin sets the sampling length. All three strobes pass through a two-flop synchroniser, and edges are found on the synchronised copies. The sampling count and the conversion count advance only on cycles where `clk_en` is high. This input stands in for either an external or an internal conversion clock.

The FSM has four states: `ST_IDLE`, `ST_SAMP_SW` (timed sampling), `ST_SAMP_HW` (pin-timed sampling) and `ST_CONV`. It has these transitions:
- IDLE→SAMP_SW on a strobe-mode trigger.
- IDLE→SAMP_HW on a pin-mode trigger.
- SAMP_SW→CONV on the last enabled sampling cycle.
- SAMP_HW→CONV on a synchronised rise of `go_pin`.
- CONV→IDLE on the last enabled conversion cycle.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A synchronous reset, applied even in mid-conversion, returns the block to idle. After reset, `samp_en`, `conv_en`, `bit_step`, `data_rdy` and `result` are all 0.
- R2: In strobe mode, a rising edge on any of `rd_strb`, `wr_strb` or `go_pin` starts sampling. `samp_en` is first high after the third rising clock edge that follows the strobe change.
- R3: In strobe mode, sampling lasts exactly 6 cycles in which `clk_en` is high. With `clk_en` held high, this is 6 clocks.
- R4: Conversion begins on the same edge that ends sampling. There is no idle cycle between the phases, and `samp_en` and `conv_en` are never high together.
- R5: Conversion lasts exactly 10 enabled cycles in both modes. `bit_step` pulses once in each enabled conversion cycle and never outside conversion.
- R6: In pin mode, `samp_en` goes high 3 clocks after `go_pin` falls. It stays high for as many clocks as the pin stayed low, and conversion follows the synchronised rise.
- R7: `sar_trial` shows the bits decided so far, with the bit under test set. Its first value is 0x200. A comparator high (`cmp_hi`=1) keeps the bit. The final result is the binary-search code, so it saturates at 1023 when the comparator is always high and reads 0 when it is always low.
- R8: A trigger that arrives during sampling or conversion is ignored. This includes, in pin mode, a fall and rise of `go_pin` during conversion. Such a trigger does not lengthen any phase or start a new one.
- R9: In pin mode, `rd_strb` and `wr_strb` are ignored. In strobe mode, a falling `go_pin` starts nothing.
- R10: `data_rdy` rises on the edge that follows the last conversion cycle. At the same edge `result` takes the new code and then holds it. `data_rdy` stays high until the edge on which the next trigger is accepted, and then clears.
- R11: While `clk_en` is low, neither phase counter advances and neither phase can end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Conversion clock enable; counters advance only when high |
| mode_hw | input | 1 | 0 = strobe mode (fixed window), 1 = pin mode (go_pin low sets the window) |
| rd_strb | input | 1 | Read strobe, rising edge triggers in strobe mode |
| wr_strb | input | 1 | Write strobe, rising edge triggers in strobe mode |
| go_pin | input | 1 | Start pin: rising edge triggers in strobe mode; low level is the window in pin mode |
| cmp_hi | input | 1 | Comparator stub: 1 when the input is at or above `sar_trial` |
| samp_en | output | 1 | Sampling phase active |
| conv_en | output | 1 | Conversion phase active |
| bit_step | output | 1 | One pulse per enabled conversion cycle |
| sar_trial | output | RES_W | Trial code offered to the comparator |
| result | output | RES_W | Latched conversion result |
| data_rdy | output | 1 | Result valid flag |

## Verification
With `clk_en` held high, the bench expects the following timing after a strobe or pin change made just after a falling edge:
- `samp_en` is first seen after the third rising edge.
- `conv_en` is first seen 6 clocks later in strobe mode, or after the pin-low length in pin mode.
- `data_rdy` with its result is seen 10 clocks after that.

The first trial code is read in the first conversion cycle. Every output is sampled at the falling edge. `bit_step` and the enabled-cycle counts are read 1 ns after `clk_en` is driven, so the bench counts exactly the cycles the design acts on. When `clk_en` is gated at random, the bench checks enabled-cycle counts instead of clock positions.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMP_SW = 2'd1,
        ST_SAMP_HW = 2'd2,
        ST_CONV    = 2'd3
    } seq_state_e;

    localparam int STRB_N  = 3;
    localparam int STRB_RD = 0;
    localparam int STRB_WR = 1;
    localparam int STRB_GO = 2;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    // each strobe: STAGES flops for metastability, one more for the edge history
    for (genvar g = 0; g < N; g++) begin : g_chan
        logic [STAGES-1:0] sync_q;
        logic              hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                hist_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[STAGES-2:0], async_in[g]};
                hist_q <= sync_q[STAGES-1];
            end
        end

        assign rise[g] =  sync_q[STAGES-1] & ~hist_q;
        assign fall[g] = ~sync_q[STAGES-1] &  hist_q;
    end

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (adv) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/sar_register.sv
module sar_register #(
    parameter int RES_W = 10,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic             last,
    input  logic [IW-1:0]    idx,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);

    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] probe;
    logic [RES_W-1:0] sar_upd;

    // step idx tests bit RES_W-1-idx (MSB first)
    always_comb begin
        probe = '0;
        for (int i = 0; i < RES_W; i++) begin
            if (idx == IW'(RES_W - 1 - i)) begin
                probe[i] = 1'b1;
            end
        end
        trial   = sar_q | probe;
        sar_upd = cmp_hi ? (sar_q | probe) : sar_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q  <= '0;
            result <= '0;
        end else if (clr) begin
            sar_q <= '0;
        end else if (step) begin
            sar_q <= sar_upd;
            if (last) begin
                result <= sar_upd;
            end
        end
    end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int SAMP_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             mode_hw,
    input  logic             rd_strb,
    input  logic             wr_strb,
    input  logic             go_pin,
    input  logic             cmp_hi,
    output logic             samp_en,
    output logic             conv_en,
    output logic             bit_step,
    output logic [RES_W-1:0] sar_trial,
    output logic [RES_W-1:0] result,
    output logic             data_rdy
);

    localparam int CNT_MAX = (SAMP_CYC > RES_W) ? SAMP_CYC : RES_W;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_e state_q, state_d;

    logic [STRB_N-1:0] strb_rise, strb_fall;
    logic [CW-1:0]     cnt;
    logic              trig, start, samp_last, conv_last, conv_done;
    logic              cnt_clr, cnt_adv;

    strobe_sync #(.N(STRB_N), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({go_pin, wr_strb, rd_strb}),
        .rise     (strb_rise),
        .fall     (strb_fall)
    );

    // mode picks which edges count as a start request
    assign trig      = mode_hw ? strb_fall[STRB_GO] : (|strb_rise);
    assign start     = (state_q == ST_IDLE) && trig;
    assign samp_last = (cnt == CW'(SAMP_CYC - 1));
    assign conv_last = (cnt == CW'(RES_W - 1));
    assign conv_done = (state_q == ST_CONV) && clk_en && conv_last;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    state_d = mode_hw ? ST_SAMP_HW : ST_SAMP_SW;
                end
            end
            ST_SAMP_SW: begin
                if (clk_en && samp_last) begin
                    state_d = ST_CONV;
                end
            end
            ST_SAMP_HW: begin
                if (strb_rise[STRB_GO]) begin
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                if (clk_en && conv_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        samp_en  = 1'b0;
        conv_en  = 1'b0;
        bit_step = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SAMP_SW: samp_en = 1'b1;
            ST_SAMP_HW: samp_en = 1'b1;
            ST_CONV: begin
                conv_en  = 1'b1;
                bit_step = clk_en;
            end
            default: ;
        endcase
    end

    assign cnt_clr = (state_q == ST_IDLE) || (state_d != state_q);
    assign cnt_adv = clk_en && ((state_q == ST_SAMP_SW) || (state_q == ST_CONV));

    phase_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .adv   (cnt_adv),
        .count (cnt)
    );

    sar_register #(.RES_W(RES_W), .IW(CW)) u_sar (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .step   (bit_step),
        .last   (conv_last),
        .idx    (cnt),
        .cmp_hi (cmp_hi),
        .trial  (sar_trial),
        .result (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_rdy <= 1'b0;
        end else if (start) begin
            data_rdy <= 1'b0;
        end else if (conv_done) begin
            data_rdy <= 1'b1;
        end
    end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W    = 10,
    parameter int SAMP_CYC = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en,
    input logic             mode_hw,
    input logic             samp_en,
    input logic             conv_en,
    input logic             bit_step,
    input logic             data_rdy,
    input logic [RES_W-1:0] result
);

    logic [7:0] samp_seen;
    logic [7:0] step_seen;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            samp_seen <= '0;
            step_seen <= '0;
        end else begin
            if (!samp_en && !conv_en) begin
                samp_seen <= '0;
            end else if (samp_en && clk_en && samp_seen != 8'hFF) begin
                samp_seen <= samp_seen + 8'd1;
            end
            if (samp_en) begin
                step_seen <= '0;
            end else if (bit_step && step_seen != 8'hFF) begin
                step_seen <= step_seen + 8'd1;
            end
        end
    end

    // R1: one cycle after reset everything is idle
    always_ff @(posedge clk) begin
        if (rst_q) begin
            p_reset_idle_r1: assert (!samp_en && !conv_en && !data_rdy && !bit_step && result == '0)
                else $error("reset state wrong");
        end
    end

    p_phase_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(samp_en && conv_en));

    p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(samp_en) && !$past(rst) |-> conv_en);

    p_samp_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_en) && !mode_hw |-> samp_seen == 8'(SAMP_CYC));

    p_step_count_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_en) && !$past(rst) |-> step_seen == 8'(RES_W) && data_rdy);

    p_conv_hold_r11: assert property (@(posedge clk) disable iff (rst)
        conv_en && !clk_en |=> conv_en);

    p_samp_hold_r11: assert property (@(posedge clk) disable iff (rst)
        samp_en && !clk_en && !mode_hw |=> samp_en);

    p_rdy_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(data_rdy) |-> $past(conv_en) && !conv_en);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        data_rdy && $past(data_rdy) |-> $stable(result));

endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES_W(RES_W), .SAMP_CYC(SAMP_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .mode_hw  (mode_hw),
    .samp_en  (samp_en),
    .conv_en  (conv_en),
    .bit_step (bit_step),
    .data_rdy (data_rdy),
    .result   (result)
);

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;

    localparam int RW = 10;
    localparam int SC = 6;

    logic clk = 1'b0;
    logic rst, clk_en, mode_hw, rd_strb, wr_strb, go_pin, cmp_hi;
    logic samp_en, conv_en, bit_step, data_rdy;
    logic [RW-1:0] sar_trial, result;
    int vin;
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    sar_seq_ctrl #(.RES_W(RW), .SAMP_CYC(SC)) u_sar_seq_ctrl (
        .clk(clk), .rst(rst), .clk_en(clk_en), .mode_hw(mode_hw),
        .rd_strb(rd_strb), .wr_strb(wr_strb), .go_pin(go_pin), .cmp_hi(cmp_hi),
        .samp_en(samp_en), .conv_en(conv_en), .bit_step(bit_step),
        .sar_trial(sar_trial), .result(result), .data_rdy(data_rdy)
    );

    // comparator stub: input code against trial
    always_comb cmp_hi = (vin >= int'(sar_trial));

    function automatic int sat_code(input int v);
        if (v <= 0) return 0;
        if (v >= (1 << RW) - 1) return (1 << RW) - 1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_strobe(input int which, input logic v);
        case (which)
            0: rd_strb = v;
            1: wr_strb = v;
            default: go_pin = v;
        endcase
    endtask

    // call just after a falling edge
    task automatic run_conv(input bit hw, input int which, input int low_len,
                            input int vin_v, input bit gated, input bit inject);
        int t, first_samp, first_conv, ready_t, samp_obs, samp_on, conv_on, steps, late_samp, inj;
        logic rdy_at2, rdy_first, prev_rdy, trial_ok;
        vin = vin_v;
        prev_rdy = data_rdy;
        first_samp = -1; first_conv = -1; ready_t = -1;
        samp_obs = 0; samp_on = 0; conv_on = 0; steps = 0; late_samp = 0;
        rdy_at2 = 1'b0; rdy_first = 1'b1; trial_ok = 1'b0;
        inj = (which + 1) % 3;
        if (hw) go_pin = 1'b0; else set_strobe(which, 1'b1);
        t = 0;
        while (t < 150 && !(ready_t >= 0 && t >= ready_t + 10)) begin
            @(negedge clk);
            t++;
            if (samp_en) begin
                samp_obs++;
                if (first_samp < 0) begin
                    first_samp = t;
                    rdy_first = data_rdy;
                end
                if (ready_t >= 0) late_samp++;
            end
            if (conv_en && first_conv < 0) begin
                first_conv = t;
                trial_ok = (sar_trial == 10'h200);
            end
            if (t == 2) rdy_at2 = data_rdy;
            if (data_rdy && ready_t < 0 && first_conv >= 0) ready_t = t;
            if (hw && t == low_len) go_pin = 1'b1;
            if (!hw && ready_t >= 0 && t == ready_t + 2) set_strobe(which, 1'b0);
            if (inject && !hw && t == 5) set_strobe(inj, 1'b1);
            if (inject && !hw && t == 7) set_strobe(inj, 1'b0);
            if (inject && hw && t == low_len + 5) go_pin = 1'b0;
            if (inject && hw && t == low_len + 7) go_pin = 1'b1;
            clk_en = gated ? (($urandom % 4) != 0) : 1'b1;
            #1;
            if (samp_en && clk_en && !hw) samp_on++;
            if (conv_en && clk_en) conv_on++;
            if (bit_step) steps++;
        end
        clk_en = 1'b1;
        chk(first_samp == 3, hw ? "R6 start latency" : "R2 start latency", first_samp, 3);
        if (hw) chk(samp_obs == low_len, "R6 window length", samp_obs, low_len);
        else begin
            chk(samp_on == SC, "R3 enabled sample cycles", samp_on, SC);
            if (!gated) chk(samp_obs == SC, "R3 sample clocks", samp_obs, SC);
        end
        chk(first_conv == first_samp + samp_obs - late_samp, "R4 no gap", first_conv,
            first_samp + samp_obs - late_samp);
        chk(steps == RW, "R5 bit steps", steps, RW);
        chk(conv_on == RW, "R11 enabled conv cycles", conv_on, RW);
        if (!gated) chk(ready_t == first_conv + RW, "R10 ready timing", ready_t, first_conv + RW);
        chk(rdy_at2 == prev_rdy, "R10 ready held before accept", int'(rdy_at2), int'(prev_rdy));
        chk(rdy_first == 1'b0, "R10 ready cleared at accept", int'(rdy_first), 0);
        chk(trial_ok, "R7 first trial", int'(trial_ok), 1);
        chk(int'(result) == sat_code(vin_v), "R7 result", int'(result), sat_code(vin_v));
        chk(late_samp == 0, "R8 R9 no retrigger", late_samp, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd20517));
        rst = 1'b1; clk_en = 1'b1; mode_hw = 1'b0;
        rd_strb = 1'b0; wr_strb = 1'b0; go_pin = 1'b0; vin = 0;
        repeat (4) @(negedge clk);
        chk(!samp_en && !conv_en && !data_rdy, "R1 reset outputs", int'({samp_en, conv_en, data_rdy}), 0);
        chk(result == '0, "R1 reset result", int'(result), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // directed strobe-mode runs
        run_conv(1'b0, 0, 0, 0, 1'b0, 1'b0);
        run_conv(1'b0, 1, 0, 1023, 1'b0, 1'b0);
        run_conv(1'b0, 2, 0, 5000, 1'b0, 1'b1);
        run_conv(1'b0, 0, 0, -40, 1'b1, 1'b0);
        run_conv(1'b0, 1, 0, 513, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) begin
            run_conv(1'b0, int'($urandom % 3), 0, int'($urandom % 1150) - 50,
                     1'(($urandom % 2)), 1'(($urandom % 2)));
        end

        // reset in mid-conversion
        rd_strb = 1'b1;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        rd_strb = 1'b0;
        @(negedge clk);
        chk(!samp_en && !conv_en && !data_rdy && !bit_step, "R1 mid-conversion reset",
            int'({samp_en, conv_en, data_rdy, bit_step}), 0);
        chk(result == '0, "R1 result after reset", int'(result), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!samp_en, "R1 stays idle", int'(samp_en), 0);

        // switch to pin mode, pin idles high
        mode_hw = 1'b1;
        @(negedge clk);
        go_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk(!samp_en, "R9 rise ignored in pin mode idle", int'(samp_en), 0);

        run_conv(1'b1, 2, 1, 300, 1'b0, 1'b0);
        run_conv(1'b1, 2, 6, 1023, 1'b0, 1'b1);
        run_conv(1'b1, 2, 20, 0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            run_conv(1'b1, 2, 1 + int'($urandom % 30), int'($urandom % 1150) - 50,
                     1'(($urandom % 2)), 1'(($urandom % 2)));
        end

        // R9: read/write strobes do nothing in pin mode
        seen = 0;
        rd_strb = 1'b1;
        repeat (3) @(negedge clk);
        wr_strb = 1'b1;
        rd_strb = 1'b0;
        repeat (3) @(negedge clk);
        wr_strb = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (samp_en) seen++;
        end
        chk(seen == 0, "R9 rd/wr ignored in pin mode", seen, 0);
        chk(data_rdy == 1'b1, "R9 ready untouched", int'(data_rdy), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule